// File: doc/BRIEF.md
# Reference-Paced Gate Window Generator

This block opens and closes the counting window of a frequency counter. Its timing comes from an external reference pulse, typically one pulse per second from a disciplined oscillator. A controller holds one of three select lines high to pick a window of 1, 10 or 100 reference periods. It pulses the reset, and the block then waits for the next rising edge of the reference. It holds `gate` high for exactly the chosen number of whole periods. When the window closes, `gate` drops and `ready` rises in the same cycle.

The window is single-shot. After it closes, `ready` stays high and `gate` stays low through any number of further reference edges, until the next reset. The reference is brought into the system clock domain through a synchronizer. The window length is counted by a chain of decade stages: each stage advances when all stages below it sit at their top value. The select lines are resolved by fixed priority and captured once, when the window opens.

Top module: `gate_window_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `gate` and `ready` are both low.
- R2: The window opens on the first rising edge of `ref_pulse` after reset. If `ref_pulse` is driven high just before system clock edge k, `gate` is still low after edge k+1 and is high after edge k+2, because of the two-flop synchronizer and the output register.
- R3: With `gate_sel` bit 0 set, `gate` is high for exactly 1 reference period. With bit 1 as the highest-priority set bit, it is high for 10 periods. With bit 2 as the highest-priority set bit, it is high for 100 periods. In each case the window closes on the reference rising edge that ends the last period.
- R4: When several select bits are high, the lowest-numbered bit wins: bit 0 (×1) before bit 1 (×10) before bit 2 (×100).
- R5: With `gate_sel` all zero, the window never opens and `ready` stays low.
- R6: `ready` rises in the same cycle that `gate` falls at the end of a window, and the two are never high together.
- R7: Once `ready` is high, it stays high and `gate` stays low until the next reset, whatever `ref_pulse` does.
- R8: If `rst` is released while `ref_pulse` is already high, that high level does not open the window. Only a later low-to-high transition does.
- R9: `gate_sel` is captured when the window opens. Changes to it while the window is open do not alter the window length.
- R10: A reset during an open window drops `gate` at once, leaves `ready` low, and re-arms the block for a full new window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Active-high synchronous reset; clears the window logic and the decade stages |
| ref_pulse | input | 1 | Active-high reference timing pulse, asynchronous to `clk` |
| gate_sel | input | DEC_STAGES+1 (3) | Window length select: bit 0 = ×1, bit 1 = ×10, bit 2 = ×100 |
| gate | output | 1 | High for the whole counting window |
| ready | output | 1 | Completion flag, held until the next reset |

## Verification
The bench builds the block with its default parameters: a two-flop synchronizer and two decade stages of ratio ten. It drives a reference with a period of 8 system clocks, so even the ×100 window lasts only 800 cycles. This makes it possible to sweep all eight select codes. For each code the bench runs a complete window, compares the measured width with the product of period and multiple, and confirms the hold-off afterwards. Hand-driven reference edges pin down the synchronizer latency and the case where reset is released while the reference is high. Separate runs cover a select change and a reset in the middle of a window.

// File: rtl/gwin_pkg.sv
package gwin_pkg;
    typedef enum logic [1:0] {
        ST_SEEK_LOW = 2'd0,
        ST_ARMED    = 2'd1,
        ST_OPEN     = 2'd2,
        ST_DONE     = 2'd3
    } gwin_state_e;
endpackage

// File: rtl/gwin_ref_sync.sv
module gwin_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic level,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    // Reset loads ones so that a reference already high at release looks steady.
    always_comb begin
        s_d      = s_q;
        s_d.pipe = {s_q.pipe[STAGES-2:0], ref_in};
        s_d.prev = s_q.pipe[STAGES-1];
        if (rst) begin
            s_d.pipe = '1;
            s_d.prev = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign level = s_q.pipe[STAGES-1];
    assign rise  = s_q.pipe[STAGES-1] & ~s_q.prev;
endmodule

// File: rtl/gwin_decade.sv
module gwin_decade #(
    parameter int RATIO = 10,
    localparam int W    = $clog2(RATIO)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] digit,
    output logic         at_last
);
    localparam logic [W-1:0] LAST = W'(RATIO - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } dec_t;

    dec_t d_d, d_q;

    always_comb begin
        d_d = d_q;
        if (rst || clr) begin
            d_d.cnt = '0;
        end else if (adv) begin
            d_d.cnt = (d_q.cnt == LAST) ? '0 : d_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        d_q <= d_d;
    end

    assign digit   = d_q.cnt;
    assign at_last = (d_q.cnt == LAST);
endmodule

// File: rtl/gwin_prio_sel.sv
module gwin_prio_sel #(
    parameter int N     = 3,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    // Scan from the top down so the lowest set bit is written last and wins.
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/gate_window_gen.sv
module gate_window_gen #(
    parameter int SYNC_STAGES = 2,
    parameter int DEC_RATIO   = 10,
    parameter int DEC_STAGES  = 2,
    localparam int NUM_SEL    = DEC_STAGES + 1,
    localparam int IDX_W      = $clog2(NUM_SEL),
    localparam int DIG_W      = $clog2(DEC_RATIO)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_pulse,
    input  logic [NUM_SEL-1:0] gate_sel,
    output logic               gate,
    output logic               ready
);
    import gwin_pkg::*;

    typedef struct packed {
        gwin_state_e      state;
        logic [IDX_W-1:0] mult;
        logic             gate;
        logic             ready;
    } ctl_t;

    ctl_t st_d, st_q;

    logic             ref_level;
    logic             ref_rise;
    logic             sel_valid;
    logic [IDX_W-1:0] sel_idx;
    logic [DEC_STAGES-1:0] dig_last;
    logic [NUM_SEL-1:0]    prefix;
    logic [DEC_STAGES*DIG_W-1:0] dig_flat;
    logic             open_evt;
    logic             close_evt;
    logic             run_rise;

    gwin_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .ref_in (ref_pulse),
        .level  (ref_level),
        .rise   (ref_rise)
    );

    gwin_prio_sel #(.N(NUM_SEL)) u_sel (
        .req   (gate_sel),
        .valid (sel_valid),
        .idx   (sel_idx)
    );

    assign run_rise  = ref_rise && (st_q.state == ST_OPEN);
    assign open_evt  = ref_rise && (st_q.state == ST_ARMED) && sel_valid;
    assign close_evt = run_rise && prefix[st_q.mult];

    // prefix[k]: every stage below k sits at its last value.
    assign prefix[0] = 1'b1;

    for (genvar j = 0; j < DEC_STAGES; j++) begin : g_dec
        gwin_decade #(.RATIO(DEC_RATIO)) u_dec (
            .clk     (clk),
            .rst     (rst),
            .clr     (open_evt),
            .adv     (run_rise && !close_evt && prefix[j]),
            .digit   (dig_flat[j*DIG_W +: DIG_W]),
            .at_last (dig_last[j])
        );
        assign prefix[j+1] = prefix[j] & dig_last[j];
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            ST_SEEK_LOW: begin
                if (!ref_level) st_d.state = ST_ARMED;
            end
            ST_ARMED: begin
                if (open_evt) begin
                    st_d.state = ST_OPEN;
                    st_d.mult  = sel_idx;
                    st_d.gate  = 1'b1;
                end
            end
            ST_OPEN: begin
                if (close_evt) begin
                    st_d.state = ST_DONE;
                    st_d.gate  = 1'b0;
                    st_d.ready = 1'b1;
                end
            end
            ST_DONE: begin
                st_d = st_q;
            end
            default: st_d.state = ST_SEEK_LOW;
        endcase
        if (rst) begin
            st_d.state = ST_SEEK_LOW;
            st_d.mult  = '0;
            st_d.gate  = 1'b0;
            st_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign gate  = st_q.gate;
    assign ready = st_q.ready;
endmodule

// File: rtl/gwin_checker.sv
module gwin_checker #(
    parameter int DEC_RATIO  = 10,
    parameter int DEC_STAGES = 2,
    parameter int NUM_SEL    = 3,
    parameter int DIG_W      = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NUM_SEL-1:0]          gate_sel,
    input logic                        gate,
    input logic                        ready,
    input gwin_pkg::gwin_state_e       state,
    input logic [DEC_STAGES*DIG_W-1:0] digits
);
    import gwin_pkg::*;

    // R6: never both high
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(gate && ready));

    // R6: a window end raises the flag in the same cycle
    a_r6_ready_on_close: assert property (@(posedge clk) disable iff (rst)
        ($fell(gate) && !$past(rst)) |-> ready);

    // R7: flag held until reset
    a_r7_ready_hold: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    // R5: no select means no window
    a_r5_no_select: assert property (@(posedge clk) disable iff (rst)
        (gate_sel == '0 && state == ST_ARMED && !gate) |=> !gate);

    // R2: window opens only from the armed state
    a_r2_open_from_armed: assert property (@(posedge clk) disable iff (rst)
        $rose(gate) |-> ($past(state) == ST_ARMED));

    // R3: every decade digit stays inside its ratio
    for (genvar j = 0; j < DEC_STAGES; j++) begin : g_rng
        a_r3_digit_range: assert property (@(posedge clk) disable iff (rst)
            digits[j*DIG_W +: DIG_W] <= DIG_W'(DEC_RATIO - 1));
    end
endmodule

bind gate_window_gen gwin_checker #(
    .DEC_RATIO  (DEC_RATIO),
    .DEC_STAGES (DEC_STAGES),
    .NUM_SEL    (NUM_SEL),
    .DIG_W      (DIG_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .gate_sel (gate_sel),
    .gate     (gate),
    .ready    (ready),
    .state    (st_q.state),
    .digits   (dig_flat)
);

// File: tb/tb_gate_window_gen.sv
`timescale 1ns/1ps
module tb_gate_window_gen;
    localparam int P  = 8;
    localparam int HI = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_pulse = 1'b0;
    logic [2:0] gate_sel = 3'b000;
    logic       gate;
    logic       ready;

    bit ref_en = 1'b1;
    int phase  = 0;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    gate_window_gen dut (
        .clk       (clk),
        .rst       (rst),
        .ref_pulse (ref_pulse),
        .gate_sel  (gate_sel),
        .gate      (gate),
        .ready     (ready)
    );

    always @(negedge clk) begin
        if (ref_en) begin
            ref_pulse <= (phase < HI);
            phase     <= (phase == P - 1) ? 0 : phase + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int mult_of(input logic [2:0] s);
        if (s[0]) return 1;
        if (s[1]) return 10;
        if (s[2]) return 100;
        return 0;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_rise(output int waited);
        waited = 0;
        while (!gate && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
    endtask

    task automatic measure(output int w);
        w = 0;
        while (gate && w < 3000) begin
            @(negedge clk);
            w++;
        end
    endtask

    initial begin
        int w;
        int wt;
        bit saw;
        repeat (4) @(negedge clk);
        chk(gate == 1'b0, "R1 gate in reset", gate, 0);
        chk(ready == 1'b0, "R1 ready in reset", ready, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!gate && !ready, "R1 after release", {gate, ready}, 0);

        // Sweep every select code: R3, R4, R5, R6, R7
        for (int s = 0; s < 8; s++) begin
            int n;
            gate_sel = 3'(s);
            n = mult_of(3'(s));
            do_reset();
            if (n == 0) begin
                saw = 1'b0;
                repeat (20 * P) begin
                    @(negedge clk);
                    saw |= gate | ready;
                end
                chk(!saw, "R5 no select never opens", saw, 0);
            end else begin
                wait_rise(wt);
                chk(gate == 1'b1, "R2 window opened", gate, 1);
                measure(w);
                if (s == 1 || s == 2 || s == 4)
                    chk(w == n * P, "R3 window width", w, n * P);
                else
                    chk(w == n * P, "R4 priority width", w, n * P);
                chk(ready == 1'b1, "R6 ready at close", ready, 1);
                saw = 1'b0;
                repeat (3 * P) begin
                    @(negedge clk);
                    saw |= gate | !ready;
                end
                chk(!saw, "R7 hold after done", saw, 0);
            end
        end

        // R9: select change mid-window ignored
        gate_sel = 3'b010;
        do_reset();
        wait_rise(wt);
        gate_sel = 3'b001;
        measure(w);
        chk(w == 10 * P, "R9 captured select", w, 10 * P);

        // R10: reset mid-window
        gate_sel = 3'b010;
        do_reset();
        wait_rise(wt);
        repeat (2 * P) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!gate && !ready, "R10 abort clears", {gate, ready}, 0);
        rst = 1'b0;
        wait_rise(wt);
        measure(w);
        chk(w == 10 * P, "R10 full window after abort", w, 10 * P);

        // R8 and R2 latency with hand-driven reference
        ref_en = 1'b0;
        @(negedge clk);
        ref_pulse = 1'b1;
        gate_sel = 3'b001;
        do_reset();
        saw = 1'b0;
        repeat (12) begin
            @(negedge clk);
            saw |= gate;
        end
        chk(!saw, "R8 high at release ignored", saw, 0);
        ref_pulse = 1'b0;
        repeat (4) @(negedge clk);
        ref_pulse = 1'b1;
        repeat (2) @(negedge clk);
        chk(gate == 1'b0, "R2 latency early", gate, 0);
        @(negedge clk);
        chk(gate == 1'b1, "R2 latency open", gate, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(150000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule